// File: doc/BRIEF.md
# Reset and Clock-Fail Supervisor

This block sequences the internal reset of a small microcontroller. It merges four reset causes into one internal reset line: a power-on event, an external reset pin, a software reset command and loss of the crystal clock. After the power-on supply detector releases, the block waits for the crystal to reach a valid level, then counts a fixed number of crystal clock pulses before it lets the core run. A software reset lasts a fixed number of clocks, and the block drives the shared reset pin high for that time. The block also watches a slow tick from the backup oscillator, and it holds the chip in reset while the crystal is stopped. When the internal reset falls, the core starts fetching at its reset vector.

The block always runs on `clk`, the backup-oscillator-derived system clock. Crystal activity arrives as a one-clock pulse, `xtal_edge`, for each crystal period. A sticky power-on flag stays set until software clears it. A two-bit cause code records which source started the most recent reset. Both can be read once the core runs.

The state machine has six states. WAIT_XTAL is the reset state and waits for `xtal_ok`. POR_HOLD counts crystal pulses. RUN means that no reset is active. PIN_HOLD, SW_HOLD and OSC_HOLD each hold one reset cause. The transitions are:
- WAIT_XTAL→POR_HOLD when `xtal_ok` is high.
- POR_HOLD→WAIT_XTAL when `xtal_ok` drops.
- POR_HOLD→RUN on the POR_CYCLES-th counted pulse.
- RUN→OSC_HOLD, RUN→PIN_HOLD and RUN→SW_HOLD, in that priority.
- PIN_HOLD→RUN once the pin is no longer accepted.
- SW_HOLD→RUN after SW_CYCLES clocks.
- OSC_HOLD→RUN when a crystal pulse clears the failure.

Top module: `rst_supervisor`

## Requirements
- R1: While `por_n` is low, `rst_out`=1, `pin_drive`=0, `por_flag`=1 and `cause`=2'b00 (power-on).
- R2: After `por_n` rises, `rst_out` stays high until POR_CYCLES `xtal_edge` pulses have been counted while `xtal_ok` is high. Counting begins only in the cycle after `xtal_ok` is seen high. A drop of `xtal_ok` restarts the count.
- R3: A `sw_rst_req` sampled while running raises `rst_out` from the next cycle for exactly SW_CYCLES clocks, and sets `cause`=2'b10.
- R4: `pin_drive` is high exactly during a software reset and low at all other times.
- R5: `por_flag` is set only by `por_n`. Other resets leave it unchanged. It is cleared only by `por_flag_clr` sampled while `rst_out` is low.
- R6: `pin_in` passes through two synchronizer flops and is accepted when two consecutive synchronized samples are high. A one-clock pulse is ignored. An accepted pin sets `cause`=2'b01 and holds reset while acceptance lasts. The block's own drive of the pin does not start a pin reset.
- R7: With `ofd_en` high, OFD_TICKS `ref_tick` pulses with no `xtal_edge` between them cause a reset with `cause`=2'b11. That reset is held until a crystal pulse is seen.
- R8: With `ofd_en` low, a stopped crystal causes no reset.
- R9: When several sources request a reset while running, the priority is oscillator failure, then pin, then software. `sw_rst_req` is ignored while a reset is active.
- R10: `cause` keeps its value while `rst_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running system clock |
| por_n | input | 1 | Asynchronous power-on reset from the supply detector, active low |
| xtal_ok | input | 1 | Crystal input has reached a valid high level |
| xtal_edge | input | 1 | One-clock pulse per crystal period |
| ref_tick | input | 1 | Slow backup-oscillator tick pulse |
| ofd_en | input | 1 | Enables the oscillator-fail reset |
| pin_in | input | 1 | Level sensed on the bidirectional reset pin (asynchronous) |
| sw_rst_req | input | 1 | Software reset command pulse |
| por_flag_clr | input | 1 | Software clear of the power-on flag |
| rst_out | output | 1 | Internal reset to the core, active high |
| pin_drive | output | 1 | Enable for the pin driver that pulls the reset pin high |
| por_flag | output | 1 | Sticky power-on status flag |
| cause | output | 2 | Cause of the last reset: 00 power-on, 01 pin, 10 software, 11 oscillator |

## Verification
The power-up path is tried three ways: with `xtal_ok` held low, with a dip of `xtal_ok` partway through the count, and with a clean count. These show whether counting waits for the level and whether a dip restarts it. The pin is driven with a one-clock glitch and with a long pulse, and the reset pin is looped back through the block's own driver. This separates a real external reset from a glitch and from the block's own drive. The crystal is stopped with detection off and then on, which shows the enable gate and how long the failure reset is held. Requests overlap in stacked scenarios (oscillator with software, pin with software) to show the priority order and that requests arriving during a reset are dropped.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_XTAL = 3'd0,
        ST_POR_HOLD  = 3'd1,
        ST_RUN       = 3'd2,
        ST_PIN_HOLD  = 3'd3,
        ST_SW_HOLD   = 3'd4,
        ST_OSC_HOLD  = 3'd5
    } rsup_state_e;

    typedef enum logic [1:0] {
        CAUSE_POWER = 2'b00,
        CAUSE_PIN   = 2'b01,
        CAUSE_SOFT  = 2'b10,
        CAUSE_OSC   = 2'b11
    } rsup_cause_e;

endpackage

// File: rtl/rsup_count.sv
// Up-counter that reports the terminal increment; cleared while idle.
module rsup_count #(
    parameter int MAX = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic done
);
    localparam int W = (MAX < 2) ? 1 : $clog2(MAX + 1);
    localparam logic [W-1:0] LAST = W'(MAX - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = inc && (cnt_q == LAST);
endmodule

// File: rtl/rsup_pin_qual.sv
// Synchronizes the reset pin and accepts it after two high samples in a row.
module rsup_pin_qual #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic pin_async,
    output logic accepted
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else if (clr) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign accepted = sync_q[SYNC_STAGES-1] & prev_q;
endmodule

// File: rtl/rsup_osc_mon.sv
// Counts backup ticks since the last crystal pulse; flags a stopped crystal.
module rsup_osc_mon #(
    parameter int TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xtal_edge,
    input  logic ref_tick,
    input  logic enable,
    output logic fail
);
    localparam int W = $clog2(TICKS + 1);
    localparam logic [W-1:0] LIMIT = W'(TICKS);

    logic [W-1:0] tick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else if (xtal_edge) begin
            tick_q <= '0;
        end else if (ref_tick && (tick_q != LIMIT)) begin
            tick_q <= tick_q + 1'b1;
        end
    end

    assign fail = enable && (tick_q == LIMIT);
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
    parameter int POR_CYCLES  = 65536,
    parameter int SW_CYCLES   = 90,
    parameter int OFD_TICKS   = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       xtal_ok,
    input  logic       xtal_edge,
    input  logic       ref_tick,
    input  logic       ofd_en,
    input  logic       pin_in,
    input  logic       sw_rst_req,
    input  logic       por_flag_clr,
    output logic       rst_out,
    output logic       pin_drive,
    output logic       por_flag,
    output logic [1:0] cause
);
    import rsup_pkg::*;

    rsup_state_e state_q, state_d;
    rsup_cause_e cause_q;
    logic        flag_q;
    logic        por_done, sw_done, pin_ok, osc_fail;

    // Power-up delay: counts crystal pulses while in POR_HOLD
    rsup_count #(.MAX(POR_CYCLES)) u_por_cnt (
        .clk   (clk),
        .rst_n (por_n),
        .clr   (state_q != ST_POR_HOLD),
        .inc   (xtal_edge),
        .done  (por_done)
    );

    // Software reset stretch: counts system clocks while in SW_HOLD
    rsup_count #(.MAX(SW_CYCLES)) u_sw_cnt (
        .clk   (clk),
        .rst_n (por_n),
        .clr   (state_q != ST_SW_HOLD),
        .inc   (1'b1),
        .done  (sw_done)
    );

    // Pin qualifier is flushed while the block drives the pin itself
    rsup_pin_qual #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
        .clk       (clk),
        .rst_n     (por_n),
        .clr       (state_q == ST_SW_HOLD),
        .pin_async (pin_in),
        .accepted  (pin_ok)
    );

    rsup_osc_mon #(.TICKS(OFD_TICKS)) u_osc (
        .clk       (clk),
        .rst_n     (por_n),
        .xtal_edge (xtal_edge),
        .ref_tick  (ref_tick),
        .enable    (ofd_en),
        .fail      (osc_fail)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_XTAL: if (xtal_ok) state_d = ST_POR_HOLD;
            ST_POR_HOLD: begin
                if (!xtal_ok)      state_d = ST_WAIT_XTAL;
                else if (por_done) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (osc_fail)        state_d = ST_OSC_HOLD;
                else if (pin_ok)     state_d = ST_PIN_HOLD;
                else if (sw_rst_req) state_d = ST_SW_HOLD;
            end
            ST_PIN_HOLD: if (!pin_ok)   state_d = ST_RUN;
            ST_SW_HOLD:  if (sw_done)   state_d = ST_RUN;
            ST_OSC_HOLD: if (!osc_fail) state_d = ST_RUN;
            default:                    state_d = ST_WAIT_XTAL;
        endcase
    end

    // State register, cause record and sticky power-on flag
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_WAIT_XTAL;
            cause_q <= CAUSE_POWER;
            flag_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN) begin
                if (state_d == ST_OSC_HOLD)      cause_q <= CAUSE_OSC;
                else if (state_d == ST_PIN_HOLD) cause_q <= CAUSE_PIN;
                else if (state_d == ST_SW_HOLD)  cause_q <= CAUSE_SOFT;
                if (por_flag_clr) flag_q <= 1'b0;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        rst_out   = 1'b1;
        pin_drive = 1'b0;
        unique case (state_q)
            ST_RUN:     rst_out   = 1'b0;
            ST_SW_HOLD: pin_drive = 1'b1;
            default: begin
                rst_out   = 1'b1;
                pin_drive = 1'b0;
            end
        endcase
    end

    assign por_flag = flag_q;
    assign cause    = cause_q;
endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk #(
    parameter int SW_CYCLES = 90
) (
    input logic       clk,
    input logic       por_n,
    input logic       rst_out,
    input logic       pin_drive,
    input logic       por_flag,
    input logic       por_flag_clr,
    input logic       sw_rst_req,
    input logic [1:0] cause
);
    int drv_cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)         drv_cnt <= 0;
        else if (pin_drive) drv_cnt <= drv_cnt + 1;
        else                drv_cnt <= 0;
    end

    // R4
    drive_in_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
        pin_drive |-> rst_out);

    // R4
    drive_cause_chk: assert property (@(posedge clk) disable iff (!por_n)
        pin_drive |-> (cause == 2'b10));

    // R3
    sw_len_chk: assert property (@(posedge clk) disable iff (!por_n)
        $fell(pin_drive) |-> (drv_cnt == SW_CYCLES));

    // R3
    sw_start_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_out && sw_rst_req) |=> rst_out);

    // R5
    flag_no_set_chk: assert property (@(posedge clk) disable iff (!por_n)
        !$rose(por_flag));

    // R5
    flag_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        $fell(por_flag) |-> ($past(por_flag_clr) && !$past(rst_out)));

    // R10
    cause_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        !rst_out |-> $stable(cause));
endmodule

bind rst_supervisor rst_supervisor_chk #(.SW_CYCLES(SW_CYCLES)) u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .rst_out      (rst_out),
    .pin_drive    (pin_drive),
    .por_flag     (por_flag),
    .por_flag_clr (por_flag_clr),
    .sw_rst_req   (sw_rst_req),
    .cause        (cause)
);

// File: tb/rst_supervisor_tb_top.sv
`timescale 1ns/1ps
module rst_supervisor_tb_top;
    localparam int POR = 64;
    localparam int SWC = 90;
    localparam int OFD = 8;

    localparam int M_WAIT = 0, M_POR = 1, M_RUN = 2, M_PIN = 3, M_SW = 4, M_OSC = 5;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic xtal_ok = 1'b0, xtal_edge = 1'b0, ref_tick = 1'b0, ofd_en = 1'b0;
    logic ext_pin = 1'b0, sw_rst_req = 1'b0, por_flag_clr = 1'b0;
    logic xtal_run = 1'b0;
    logic rst_out, pin_drive, por_flag;
    logic [1:0] cause;
    wire pin_in = ext_pin | pin_drive;   // wired reset pin with block's own driver

    int checks = 0, errors = 0, cyc = 0;
    bit cmp_en = 0;

    always #2.5 clk = ~clk;

    rst_supervisor #(.POR_CYCLES(POR), .SW_CYCLES(SWC), .OFD_TICKS(OFD)) dut_i (
        .clk(clk), .por_n(por_n), .xtal_ok(xtal_ok), .xtal_edge(xtal_edge),
        .ref_tick(ref_tick), .ofd_en(ofd_en), .pin_in(pin_in),
        .sw_rst_req(sw_rst_req), .por_flag_clr(por_flag_clr),
        .rst_out(rst_out), .pin_drive(pin_drive), .por_flag(por_flag), .cause(cause)
    );

    // Crystal pulses every other cycle while running; backup tick every 5 cycles
    always @(negedge clk) begin
        cyc       <= cyc + 1;
        xtal_edge <= xtal_run && cyc[0];
        ref_tick  <= (cyc % 5) == 0;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int m_mode, m_rem, m_tcnt, m_cause;
    bit m_flag;
    bit hist[3];

    always @(posedge clk or negedge por_n) begin : model
        bit pin_now, pin_ok, osc_now;
        if (!por_n) begin
            m_mode = M_WAIT; m_rem = 0; m_tcnt = 0; m_cause = 0; m_flag = 1;
            hist[0] = 0; hist[1] = 0; hist[2] = 0;
        end else begin
            pin_now = ext_pin | (m_mode == M_SW);
            pin_ok  = hist[1] & hist[2];
            osc_now = ofd_en && (m_tcnt >= OFD);
            if (xtal_edge) m_tcnt = 0;
            else if (ref_tick && m_tcnt < OFD) m_tcnt++;
            if (m_mode == M_SW) begin
                hist[0] = 0; hist[1] = 0; hist[2] = 0;
            end else begin
                hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = pin_now;
            end
            case (m_mode)
                M_WAIT: if (xtal_ok) begin m_mode = M_POR; m_rem = POR; end
                M_POR: begin
                    if (!xtal_ok) m_mode = M_WAIT;
                    else if (xtal_edge) begin
                        m_rem--;
                        if (m_rem == 0) m_mode = M_RUN;
                    end
                end
                M_RUN: begin
                    if (por_flag_clr) m_flag = 0;
                    if (osc_now)         begin m_mode = M_OSC; m_cause = 3; end
                    else if (pin_ok)     begin m_mode = M_PIN; m_cause = 1; end
                    else if (sw_rst_req) begin m_mode = M_SW; m_rem = SWC; m_cause = 2; end
                end
                M_PIN: if (!pin_ok) m_mode = M_RUN;
                M_SW: begin
                    m_rem--;
                    if (m_rem == 0) m_mode = M_RUN;
                end
                M_OSC: if (!osc_now) m_mode = M_RUN;
                default: m_mode = M_WAIT;
            endcase
        end
    end

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_en) begin
            check("R2 rst_out vs model", int'(rst_out), int'(m_mode != M_RUN));
            check("R4 pin_drive vs model", int'(pin_drive), int'(m_mode == M_SW));
            check("R5 por_flag vs model", int'(por_flag), int'(m_flag));
            check("R10 cause vs model", int'(cause), m_cause);
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sw();
        @(negedge clk); sw_rst_req = 1'b1;
        @(negedge clk); sw_rst_req = 1'b0;
    endtask

    task automatic run_tests();
        int hi;
        cycles(5);
        check("R1 rst_out in reset", int'(rst_out), 1);
        check("R1 pin_drive in reset", int'(pin_drive), 0);
        check("R1 por_flag in reset", int'(por_flag), 1);
        check("R1 cause in reset", int'(cause), 0);
        #1 por_n = 1'b1;
        cmp_en = 1;

        // R2: no counting without a valid crystal level
        xtal_run = 1'b1;
        cycles(150);
        check("R2 held without xtal_ok", int'(rst_out), 1);
        xtal_ok = 1'b1;
        cycles(60);
        xtal_ok = 1'b0;
        cycles(3);
        xtal_ok = 1'b1;
        cycles(100);
        check("R2 held after restart", int'(rst_out), 1);
        cycles(60);
        check("R2 released", int'(rst_out), 0);
        check("R1 cause power-on", int'(cause), 0);

        // R3/R4: software reset with a flag clear attempt inside it (R5)
        pulse_sw();
        check("R3 reset raised", int'(rst_out), 1);
        hi = 1;
        @(negedge clk); por_flag_clr = 1'b1;
        @(negedge clk); por_flag_clr = 1'b0;
        hi += 2;
        while (pin_drive) begin @(negedge clk); if (pin_drive) hi++; end
        check("R3 software reset length", hi, SWC);
        check("R3 cause software", int'(cause), 2);
        check("R5 flag kept through clear during reset", int'(por_flag), 1);
        cycles(6);
        check("R6 own drive not re-read", int'(rst_out), 0);

        // R5: clear while running
        @(negedge clk); por_flag_clr = 1'b1;
        @(negedge clk); por_flag_clr = 1'b0;
        check("R5 flag cleared", int'(por_flag), 0);
        pulse_sw();
        cycles(SWC + 4);
        check("R5 flag not set by software reset", int'(por_flag), 0);

        // R6: glitch then real pin reset, software request ignored inside (R9)
        @(negedge clk); ext_pin = 1'b1;
        @(negedge clk); ext_pin = 1'b0;
        cycles(6);
        check("R6 glitch ignored", int'(rst_out), 0);
        ext_pin = 1'b1;
        cycles(8);
        check("R6 pin reset active", int'(rst_out), 1);
        check("R6 cause pin", int'(cause), 1);
        pulse_sw();
        ext_pin = 1'b0;
        cycles(6);
        check("R6 pin reset released", int'(rst_out), 0);
        check("R9 request during reset ignored", int'(cause), 1);

        // R8: detection off
        xtal_run = 1'b0;
        cycles(100);
        check("R8 stopped crystal, detection off", int'(rst_out), 0);
        xtal_run = 1'b1;
        cycles(6);

        // R7: detection on
        ofd_en = 1'b1;
        xtal_run = 1'b0;
        cycles(60);
        check("R7 oscillator fail reset", int'(rst_out), 1);
        check("R7 cause oscillator", int'(cause), 3);
        cycles(100);
        check("R7 held while stopped", int'(rst_out), 1);
        xtal_run = 1'b1;
        cycles(6);
        check("R7 released on crystal", int'(rst_out), 0);

        // R9: oscillator beats software, pin beats software
        ext_pin = 1'b1;
        cycles(8);
        xtal_run = 1'b0;
        cycles(60);
        sw_rst_req = 1'b1;
        ext_pin = 1'b0;
        cycles(8);
        check("R9 oscillator over software", int'(cause), 3);
        ext_pin = 1'b1;
        cycles(6);
        xtal_run = 1'b1;
        cycles(8);
        check("R9 pin over software", int'(cause), 1);
        ext_pin = 1'b0;
        sw_rst_req = 1'b0;
        cycles(8);
        check("R9 pin reset ended", int'(rst_out), 0);
        ofd_en = 1'b0;

        // R1/R5: power-on again sets the flag
        #1 por_n = 1'b0;
        cycles(3);
        check("R5 flag set by power-on", int'(por_flag), 1);
        check("R1 cause reset", int'(cause), 0);
        #1 por_n = 1'b1;
        cycles(200);
        check("R2 released after second power-on", int'(rst_out), 0);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule